// File: doc/BRIEF.md
# Buffered Half-Duplex SPI Master

This block is a memory-mapped SPI master built around a shared eight-byte data buffer. Software fills the buffer, programs the configuration word and then writes a single command word. That write starts one half-duplex transfer. The command carries a total byte count and a transmit byte count. The controller first shifts out the transmit bytes, taking them from buffer entries 0 upward. It then clocks in the remaining bytes and stores them in the same buffer, again from entry 0 upward.

A status word reports three things: a busy flag, a completion interrupt and the number of bytes received by the last command. The serial clock runs at the core clock divided by twice a 13-bit divider. The idle level of the clock, the bit order, the chip-select polarity and a per-line chip-select enable can all be set. A programmable gap of whole serial-clock periods can be placed before each command. A per-command flag keeps the selected chip select asserted after the command ends, so that several commands can form one longer bus transaction.

Top module: `spi_buf_master`

## Requirements
- R1: After reset every register reads zero. The output enables are low. All four chip-select outputs sit at their inactive level, which is high because the polarity bit resets to 0.
- R2: The configuration word is at 0x00 and reads back as written. Its fields are: enable at bit 0, clock idles low at bit 1, LSB first at bit 4, chip-select active high at bit 7, gap periods at bits 9:8, per-line chip-select enables at bits 15:12, and the divider at bits 28:16. The status word is at 0x08, the command word at 0x10, and data entry i at 0x80 + 8*i.
- R3: Each half period of the serial clock lasts max(divider,1) core cycles. A command keeps busy (status bit 0) high for exactly max(divider,1) * (2*gap + 16*total + 1) cycles.
- R4: Transmit bytes come from entries 0 upward, and only the low 8 bits of each entry are sent. The bit order is MSB first when config bit 4 is 0 and LSB first when it is 1.
- R5: Command fields are: total at bits 4:0, clamped to 8; transmit count at bits 12:8, clamped to the total; hold at bit 16; chip-select index at bits 21:20. Received bytes land in entries 0 upward with the upper bits zero. Status bits 12:8 give total minus transmit count.
- R6: A transmit count of zero makes every byte a received byte. MOSI is held low while bytes are being received.
- R7: The serial clock rests at the level given by config bit 1 (1 means low) whenever no command is in progress. MISO is sampled on the first edge after chip select asserts, and MOSI changes on the second edge.
- R8: During a command only the line chosen by the command index is asserted, and only if its enable bit in config bits 15:12 is set. Config bit 7 gives the active level. At most one line is asserted at any time.
- R9: A non-zero gap field adds that many full serial-clock periods, with the clock idle, before chip select asserts.
- R10: With hold set, the chosen chip select stays asserted after the command ends. With hold clear, it deasserts at the end.
- R11: A command write while busy is ignored. The transfer in progress and the command readback are unchanged.
- R12: Status bit 1 is set when a command completes. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R13: The SCLK, MOSI and chip-select output enables follow config bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Register byte address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for req_addr (combinational) |
| sclk_o | output | 1 | Serial clock |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data output enable |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |
| cs_oe | output | 1 | Chip-select output enable |
| irq_o | output | 1 | Completion interrupt level |

## Verification
The assertions assume that the configuration word is not rewritten while a command is in progress. The single-asserted-line and idle-clock properties read polarity and idle level from the live configuration, so the bench only reprograms the configuration after busy has dropped. The assertions also assume MISO is settled before each sampling edge. The bench's slave model therefore changes MISO only half a core cycle after a trailing clock edge, which always comes at least one full core cycle before the next sampling edge.

// File: rtl/spi_buf_pkg.sv
`timescale 1ns/1ps
package spi_buf_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int BYTE_W     = 8;
    localparam int BUF_DEPTH  = 8;
    localparam int CNT_W      = 5;
    localparam int DIV_W      = 13;
    localparam int NUM_CS     = 4;
    localparam int CS_IDX_W   = 2;
    localparam int GAP_W      = 2;

    localparam logic [ADDR_W-1:0] A_CFG  = 8'h00;
    localparam logic [ADDR_W-1:0] A_STAT = 8'h08;
    localparam logic [ADDR_W-1:0] A_CMD  = 8'h10;
    localparam logic [ADDR_W-1:0] A_BUF  = 8'h80;
    localparam int BUF_STRIDE_LG = 3;

    localparam int CMD_TOT_LSB  = 0;
    localparam int CMD_TX_LSB   = 8;
    localparam int CMD_HOLD_BIT = 16;
    localparam int CMD_CS_LSB   = 20;

    localparam int ST_BUSY_BIT = 0;
    localparam int ST_IRQ_BIT  = 1;
    localparam int ST_RXN_LSB  = 8;

    // Configuration word, LSB at the bottom of the list.
    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [NUM_CS-1:0] cs_en;
        logic              cs_late;
        logic              tristate;
        logic [GAP_W-1:0]  gap;
        logic              cs_high;
        logic [1:0]        spare;
        logic              lsb_first;
        logic              wire_or;
        logic              clk_cont;
        logic              idle_low;
        logic              enable;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef struct packed {
        logic [CS_IDX_W-1:0] cs_idx;
        logic                hold;
        logic [CNT_W-1:0]    txn;
        logic [CNT_W-1:0]    total;
    } cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_LO,
        ST_HI,
        ST_TAIL
    } eng_state_e;

    function automatic cmd_t cmd_decode(input logic [DATA_W-1:0] w);
        cmd_t c;
        logic [CNT_W-1:0] t;
        logic [CNT_W-1:0] x;
        t = w[CMD_TOT_LSB +: CNT_W];
        x = w[CMD_TX_LSB +: CNT_W];
        if (t > CNT_W'(BUF_DEPTH)) t = CNT_W'(BUF_DEPTH);
        if (x > t) x = t;
        c.total  = t;
        c.txn    = x;
        c.hold   = w[CMD_HOLD_BIT];
        c.cs_idx = w[CMD_CS_LSB +: CS_IDX_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cmd_encode(input cmd_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CMD_TOT_LSB +: CNT_W]   = c.total;
        w[CMD_TX_LSB +: CNT_W]    = c.txn;
        w[CMD_HOLD_BIT]           = c.hold;
        w[CMD_CS_LSB +: CS_IDX_W] = c.cs_idx;
        return w;
    endfunction

    function automatic logic lead_bit(input logic [BYTE_W-1:0] b, input logic lsb);
        return lsb ? b[0] : b[BYTE_W-1];
    endfunction

    function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] b,
                                                   input logic d, input logic lsb);
        return lsb ? {d, b[BYTE_W-1:1]} : {b[BYTE_W-2:0], d};
    endfunction

endpackage

// File: rtl/spi_buf_clkgen.sv
`timescale 1ns/1ps
module spi_buf_clkgen #(
    parameter int DIV_W = spi_buf_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] reload;

    assign reload = (div == '0) ? '0 : div - 1'b1;
    assign tick   = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/spi_buf_regs.sv
`timescale 1ns/1ps
module spi_buf_regs
    import spi_buf_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic [DATA_W-1:0]        rd_data,
    output cfg_t                     cfg,
    output logic                     start,
    output cmd_t                     cmd_new,
    output cmd_t                     cmd_rb,
    input  logic                     busy,
    input  logic                     done,
    input  logic [CNT_W-1:0]         rx_total,
    input  logic [$clog2(DEPTH)-1:0] tx_idx,
    output logic [BYTE_W-1:0]        tx_byte,
    input  logic                     rx_we,
    input  logic [$clog2(DEPTH)-1:0] rx_idx,
    input  logic [BYTE_W-1:0]        rx_byte,
    output logic                     irq,
    output logic [CNT_W-1:0]         rxnum
);
    localparam int IDX_W    = $clog2(DEPTH);
    localparam int BUF_SPAN = DEPTH << BUF_STRIDE_LG;

    logic [BYTE_W-1:0] mem_q [DEPTH];
    cfg_t              cfg_q;
    cmd_t              cmd_q;
    logic              irq_q;
    logic [CNT_W-1:0]  rxnum_q;

    logic              wr;
    logic              hit_buf;
    logic [ADDR_W-1:0] buf_off;
    logic [IDX_W-1:0]  buf_idx;

    assign wr      = req_valid && req_write;
    assign buf_off = req_addr - A_BUF;
    assign hit_buf = (req_addr >= A_BUF) && (32'(buf_off) < BUF_SPAN)
                     && (buf_off[BUF_STRIDE_LG-1:0] == '0);
    assign buf_idx = buf_off[BUF_STRIDE_LG +: IDX_W];

    assign cmd_new = cmd_decode(req_wdata);
    assign start   = wr && (req_addr == A_CMD) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            cmd_q   <= '0;
            irq_q   <= 1'b0;
            rxnum_q <= '0;
        end else begin
            if (wr && req_addr == A_CFG) cfg_q <= cfg_t'(req_wdata[CFG_W-1:0]);
            if (start) begin
                cmd_q   <= cmd_new;
                rxnum_q <= '0;
            end
            if (done) begin
                rxnum_q <= rx_total;
                irq_q   <= 1'b1;
            end else if (wr && req_addr == A_STAT && req_wdata[ST_IRQ_BIT]) begin
                irq_q <= 1'b0;
            end
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem_q[g] <= '0;
                end else if (rx_we && rx_idx == IDX_W'(g)) begin
                    mem_q[g] <= rx_byte;
                end else if (wr && hit_buf && buf_idx == IDX_W'(g)) begin
                    mem_q[g] <= req_wdata[BYTE_W-1:0];
                end
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (req_addr == A_CFG) begin
            rd_data[CFG_W-1:0] = cfg_q;
        end else if (req_addr == A_STAT) begin
            rd_data[ST_BUSY_BIT]            = busy;
            rd_data[ST_IRQ_BIT]             = irq_q;
            rd_data[ST_RXN_LSB +: CNT_W]    = rxnum_q;
        end else if (req_addr == A_CMD) begin
            rd_data = cmd_encode(cmd_q);
        end else if (hit_buf) begin
            rd_data[BYTE_W-1:0] = mem_q[buf_idx];
        end
    end

    assign tx_byte = mem_q[tx_idx];
    assign cfg     = cfg_q;
    assign cmd_rb  = cmd_q;
    assign irq     = irq_q;
    assign rxnum   = rxnum_q;
endmodule

// File: rtl/spi_buf_engine.sv
`timescale 1ns/1ps
module spi_buf_engine
    import spi_buf_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst,
    input  cfg_t                     cfg,
    input  logic                     start,
    input  cmd_t                     cmd_new,
    input  logic                     tick,
    input  logic                     miso,
    output logic                     run,
    output logic [$clog2(DEPTH)-1:0] tx_idx,
    input  logic [BYTE_W-1:0]        tx_byte,
    output logic                     rx_we,
    output logic [$clog2(DEPTH)-1:0] rx_idx,
    output logic [BYTE_W-1:0]        rx_byte,
    output logic [CNT_W-1:0]         rx_total,
    output logic                     busy,
    output logic                     done,
    output logic                     sclk_lvl,
    output logic                     mosi_bit,
    output logic                     cs_on,
    output logic [CS_IDX_W-1:0]      cs_sel
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    eng_state_e         state_q;
    cmd_t               cmd_q;
    cmd_t               first;
    logic [CNT_W-1:0]   byte_q;
    logic [CNT_W-1:0]   next_byte;
    logic [BIT_W-1:0]   bit_q;
    logic [GAP_W:0]     gap_q;
    logic [BYTE_W-1:0]  sh_q;
    logic               mosi_q;
    logic               cs_on_q;
    logic [CS_IDX_W-1:0] cs_sel_q;
    logic               is_tx;
    logic               go_first;
    logic               byte_end;

    assign first     = (state_q == ST_IDLE) ? cmd_new : cmd_q;
    assign is_tx     = byte_q < cmd_q.txn;
    assign next_byte = byte_q + 1'b1;
    assign byte_end  = (state_q == ST_HI) && tick && (bit_q == LAST_BIT);
    assign go_first  = ((state_q == ST_IDLE) && start && (cfg.gap == '0))
                     || ((state_q == ST_GAP) && tick && (gap_q == (GAP_W+1)'(1)));

    assign tx_idx   = (state_q == ST_HI) ? next_byte[IDX_W-1:0] : '0;
    assign rx_we    = byte_end && !is_tx;
    assign rx_idx   = IDX_W'(byte_q - cmd_q.txn);
    assign rx_byte  = sh_q;
    assign rx_total = cmd_q.total - cmd_q.txn;
    assign busy     = (state_q != ST_IDLE);
    assign run      = busy;
    assign done     = (state_q == ST_TAIL) && tick;
    assign sclk_lvl = (~cfg.idle_low) ^ (state_q == ST_HI);
    assign mosi_bit = mosi_q;
    assign cs_on    = cs_on_q;
    assign cs_sel   = cs_sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cmd_q    <= '0;
            byte_q   <= '0;
            bit_q    <= '0;
            gap_q    <= '0;
            sh_q     <= '0;
            mosi_q   <= 1'b0;
            cs_on_q  <= 1'b0;
            cs_sel_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cmd_q   <= cmd_new;
                        gap_q   <= {cfg.gap, 1'b0};
                        state_q <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tick) gap_q <= gap_q - 1'b1;
                end
                ST_LO: begin
                    if (tick) begin
                        sh_q    <= shift_in(sh_q, miso, cfg.lsb_first);
                        state_q <= ST_HI;
                    end
                end
                ST_HI: begin
                    if (tick) begin
                        if (bit_q == LAST_BIT) begin
                            if (next_byte == cmd_q.total) begin
                                mosi_q  <= 1'b0;
                                state_q <= ST_TAIL;
                            end else begin
                                byte_q  <= next_byte;
                                bit_q   <= '0;
                                sh_q    <= tx_byte;
                                mosi_q  <= (next_byte < cmd_q.txn) ?
                                           lead_bit(tx_byte, cfg.lsb_first) : 1'b0;
                                state_q <= ST_LO;
                            end
                        end else begin
                            bit_q   <= bit_q + 1'b1;
                            mosi_q  <= is_tx ? lead_bit(sh_q, cfg.lsb_first) : 1'b0;
                            state_q <= ST_LO;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        cs_on_q <= cmd_q.hold;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase

            if (go_first) begin
                cs_on_q  <= 1'b1;
                cs_sel_q <= first.cs_idx;
                byte_q   <= '0;
                bit_q    <= '0;
                sh_q     <= tx_byte;
                mosi_q   <= (first.txn != '0) ? lead_bit(tx_byte, cfg.lsb_first) : 1'b0;
                state_q  <= (first.total == '0) ? ST_TAIL : ST_LO;
            end
        end
    end
endmodule

// File: rtl/spi_buf_master.sv
`timescale 1ns/1ps
module spi_buf_master
    import spi_buf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rd_data,
    output logic              sclk_o,
    output logic              sclk_oe,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic [3:0]        cs_o,
    output logic              cs_oe,
    output logic              irq_o
);
    localparam int IDX_W = $clog2(BUF_DEPTH);

    cfg_t                cfg;
    cmd_t                cmd_new;
    cmd_t                cmd_rb;
    logic                start;
    logic                busy;
    logic                done;
    logic                tick;
    logic                run;
    logic [IDX_W-1:0]    tx_idx;
    logic [BYTE_W-1:0]   tx_byte;
    logic                rx_we;
    logic [IDX_W-1:0]    rx_idx;
    logic [BYTE_W-1:0]   rx_byte;
    logic [CNT_W-1:0]    rx_total;
    logic [CNT_W-1:0]    rxnum;
    logic                sclk_lvl;
    logic                mosi_bit;
    logic                cs_on;
    logic [CS_IDX_W-1:0] cs_sel;
    logic                cmd_wr;
    logic                cs_high;
    logic                idle_low;

    assign cmd_wr   = req_valid && req_write && (req_addr == A_CMD);
    assign cs_high  = cfg.cs_high;
    assign idle_low = cfg.idle_low;

    spi_buf_regs #(.DEPTH(BUF_DEPTH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .cfg       (cfg),
        .start     (start),
        .cmd_new   (cmd_new),
        .cmd_rb    (cmd_rb),
        .busy      (busy),
        .done      (done),
        .rx_total  (rx_total),
        .tx_idx    (tx_idx),
        .tx_byte   (tx_byte),
        .rx_we     (rx_we),
        .rx_idx    (rx_idx),
        .rx_byte   (rx_byte),
        .irq       (irq_o),
        .rxnum     (rxnum)
    );

    spi_buf_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .div  (cfg.div),
        .tick (tick)
    );

    spi_buf_engine #(.DEPTH(BUF_DEPTH)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .start    (start),
        .cmd_new  (cmd_new),
        .tick     (tick),
        .miso     (miso_i),
        .run      (run),
        .tx_idx   (tx_idx),
        .tx_byte  (tx_byte),
        .rx_we    (rx_we),
        .rx_idx   (rx_idx),
        .rx_byte  (rx_byte),
        .rx_total (rx_total),
        .busy     (busy),
        .done     (done),
        .sclk_lvl (sclk_lvl),
        .mosi_bit (mosi_bit),
        .cs_on    (cs_on),
        .cs_sel   (cs_sel)
    );

    generate
        for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
            assign cs_o[g] = (cs_on && cs_sel == CS_IDX_W'(g) && cfg.cs_en[g])
                             ? cfg.cs_high : ~cfg.cs_high;
        end
    endgenerate

    assign sclk_o  = sclk_lvl;
    assign mosi_o  = mosi_bit;
    assign sclk_oe = cfg.enable;
    assign mosi_oe = cfg.enable;
    assign cs_oe   = cfg.enable;
endmodule

module spi_buf_master_chk
    import spi_buf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             cmd_wr,
    input cmd_t             cmd_rb,
    input logic             irq_o,
    input logic [3:0]       cs_o,
    input logic             cs_high,
    input logic             idle_low,
    input logic             sclk_o,
    input logic [CNT_W-1:0] rxnum
);
    logic [3:0] cs_act;
    assign cs_act = cs_o ^ {4{~cs_high}};

    p_single_cs_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(cs_act) <= 1);

    p_cmd_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_wr) |=> $stable(cmd_rb));

    p_irq_on_done_r12: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq_o);

    p_sclk_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk_o == ~idle_low));

    p_rxnum_bound_r5: assert property (@(posedge clk) disable iff (rst)
        rxnum <= CNT_W'(BUF_DEPTH));
endmodule

bind spi_buf_master spi_buf_master_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .cmd_wr   (cmd_wr),
    .cmd_rb   (cmd_rb),
    .irq_o    (irq_o),
    .cs_o     (cs_o),
    .cs_high  (cs_high),
    .idle_low (idle_low),
    .sclk_o   (sclk_o),
    .rxnum    (rxnum)
);

// File: tb/spi_buf_master_tb.sv
`timescale 1ns/1ps
module spi_buf_master_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        sclk_o, sclk_oe, mosi_o, mosi_oe, cs_oe, irq_o;
    logic        miso_i = 1'b0;
    logic [3:0]  cs_o;

    int errors = 0;
    int checks = 0;

    // bench-side view of the configuration in force
    logic b_lsb = 0, b_high = 0, b_idle_low = 0, b_full_en = 0;
    int   b_div = 1;
    int   b_gap = 0;

    // slave model
    logic cap [0:127];
    int   ncap = 0;
    int   nmiso = 0;
    logic [3:0] cs_seen = '0;
    logic prev_sclk = 1'b1;

    spi_buf_master u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .sclk_o(sclk_o), .sclk_oe(sclk_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .cs_o(cs_o), .cs_oe(cs_oe), .irq_o(irq_o)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] slv_byte(input int k);
        return 8'((k * 59 + 150) & 255);
    endfunction

    function automatic logic slv_bit(input int n);
        logic [7:0] b;
        b = slv_byte(n / 8);
        return b_lsb ? b[n % 8] : b[7 - (n % 8)];
    endfunction

    function automatic logic [7:0] cap_byte(input int k);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) begin
            if (b_lsb) b[i] = cap[k*8+i];
            else       b[7-i] = cap[k*8+i];
        end
        return b;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // slave model and per-clock invariants
    always @(negedge clk) begin
        if (!rst) begin
            logic [3:0] act;
            logic idle_lvl;
            act = b_high ? cs_o : ~cs_o;
            idle_lvl = ~b_idle_low;
            cs_seen = cs_seen | act;
            if ($countones(act) > 1) begin
                errors++; checks++;
                $display("FAIL R8 actual=%0h expected=one-hot", act);
            end
            if (b_full_en && act == 4'b0 && sclk_o != idle_lvl) begin
                errors++; checks++;
                $display("FAIL R7 actual=%0b expected=%0b", sclk_o, idle_lvl);
            end
            if (prev_sclk == idle_lvl && sclk_o != idle_lvl) begin
                if (ncap < 128) cap[ncap] = mosi_o;
                ncap++;
            end else if (prev_sclk != idle_lvl && sclk_o == idle_lvl) begin
                nmiso++;
                miso_i = slv_bit(nmiso);
            end
            prev_sclk = sclk_o;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        req_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic set_cfg(input bit en, input bit idle_low, input bit lsb, input bit high,
                           input int gap, input logic [3:0] csen, input int div);
        logic [31:0] w;
        w = 0;
        w[0] = en; w[1] = idle_low; w[4] = lsb; w[7] = high;
        w[9:8] = 2'(gap); w[15:12] = csen; w[28:16] = 13'(div);
        b_lsb = lsb; b_high = high; b_idle_low = idle_low;
        b_full_en = (csen == 4'hF);
        b_div = (div == 0) ? 1 : div; b_gap = gap;
        prev_sclk = ~idle_low;
        wr(8'h00, w);
    endtask

    task automatic run_cmd(input int total, input int txn, input bit hold, input int idx,
                           output int cyc);
        logic [31:0] w, s;
        w = 0;
        w[4:0] = 5'(total); w[12:8] = 5'(txn); w[16] = hold; w[21:20] = 2'(idx);
        ncap = 0; nmiso = 0; cs_seen = '0;
        miso_i = slv_bit(0);
        wr(8'h10, w);
        cyc = 0;
        rd(8'h08, s);
        while (s[0] && cyc < 20000) begin
            cyc++;
            @(negedge clk);
            rd(8'h08, s);
        end
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int cyc;
        int exp;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state
        rd(8'h00, d); check(d == 0, "R1 cfg", d, 0);
        rd(8'h08, d); check(d == 0, "R1 status", d, 0);
        check(cs_o == 4'hF, "R1 cs", cs_o, 4'hF);
        check({sclk_oe, mosi_oe, cs_oe} == 3'b0, "R13 oe at reset", {sclk_oe, mosi_oe, cs_oe}, 0);

        // R2 config readback, R13 enables
        set_cfg(1, 0, 0, 0, 0, 4'hF, 2);
        rd(8'h00, d);
        check(d == 32'h0002_F001, "R2 cfg readback", d, 32'h0002_F001);
        check({sclk_oe, mosi_oe, cs_oe} == 3'b111, "R13 oe on", {sclk_oe, mosi_oe, cs_oe}, 7);

        // R4 transmit only, MSB first; upper bits of entry ignored
        wr(8'h80, 32'hA5); wr(8'h88, 32'h3C); wr(8'h90, 32'hFF81);
        rd(8'h90, d); check(d == 32'h81, "R2 data entry low byte", d, 32'h81);
        run_cmd(3, 3, 0, 1, cyc);
        exp = 2 * (16 * 3 + 1);
        check(cyc == exp, "R3 busy length div2", cyc, exp);
        check(ncap == 24, "R4 bit count", ncap, 24);
        check(cap_byte(0) == 8'hA5, "R4 byte0", cap_byte(0), 8'hA5);
        check(cap_byte(1) == 8'h3C, "R4 byte1", cap_byte(1), 8'h3C);
        check(cap_byte(2) == 8'h81, "R4 byte2", cap_byte(2), 8'h81);
        check(cs_seen == 4'b0010, "R8 line 1", cs_seen, 4'b0010);
        check(cs_o == 4'hF, "R10 released", cs_o, 4'hF);
        rd(8'h08, d);
        check(d[1] == 1, "R12 irq set", d[1], 1);
        check(d[12:8] == 0, "R5 rxnum zero", d[12:8], 0);
        check(irq_o == 1, "R12 irq pin", irq_o, 1);

        // R12 W1C
        wr(8'h08, 32'h0); rd(8'h08, d); check(d[1] == 1, "R12 write 0 keeps", d[1], 1);
        wr(8'h08, 32'h2); rd(8'h08, d); check(d[1] == 0, "R12 write 1 clears", d[1], 0);

        // R5 mixed: one tx then three rx
        wr(8'h80, 32'h5E);
        run_cmd(4, 1, 0, 0, cyc);
        check(cap_byte(0) == 8'h5E, "R4 tx before rx", cap_byte(0), 8'h5E);
        for (int j = 0; j < 3; j++) begin
            rd(8'(8'h80 + 8 * j), d);
            check(d == {24'h0, slv_byte(j + 1)}, "R5 rx entry", d, slv_byte(j + 1));
        end
        rd(8'h08, d); check(d[12:8] == 3, "R5 rxnum", d[12:8], 3);
        begin
            bit quiet;
            quiet = 1;
            for (int i = 8; i < 32; i++) if (cap[i] !== 1'b0) quiet = 0;
            check(quiet, "R6 mosi low in rx", quiet, 1);
        end

        // R6 all receive, R9 gap, R7 idle low, R4 LSB first, R8 active high, idx 3
        set_cfg(1, 1, 1, 1, 2, 4'hF, 3);
        check(cs_o == 4'h0, "R8 inactive high-polarity", cs_o, 0);
        check(sclk_o == 1'b0, "R7 idle low", sclk_o, 0);
        run_cmd(2, 0, 0, 3, cyc);
        exp = 3 * (4 + 32 + 1);
        check(cyc == exp, "R9 gap length", cyc, exp);
        check(cs_seen == 4'b1000, "R8 line 3", cs_seen, 4'b1000);
        rd(8'h80, d); check(d[7:0] == slv_byte(0), "R6 rx0 lsb", d[7:0], slv_byte(0));
        rd(8'h88, d); check(d[7:0] == slv_byte(1), "R6 rx1 lsb", d[7:0], slv_byte(1));

        // R4 LSB first transmit
        wr(8'h80, 32'h1D);
        run_cmd(1, 1, 0, 3, cyc);
        check(cap_byte(0) == 8'h1D, "R4 lsb tx", cap_byte(0), 8'h1D);

        // R10 hold
        set_cfg(1, 0, 0, 0, 0, 4'hF, 1);
        run_cmd(1, 1, 1, 2, cyc);
        check(cs_o == 4'b1011, "R10 held", cs_o, 4'b1011);
        run_cmd(1, 1, 0, 2, cyc);
        check(cs_o == 4'hF, "R10 released after", cs_o, 4'hF);

        // R5 clamp and R3 divider zero
        set_cfg(1, 0, 0, 0, 0, 4'hF, 0);
        run_cmd(12, 0, 0, 0, cyc);
        check(cyc == 129, "R3 div zero", cyc, 129);
        rd(8'h08, d); check(d[12:8] == 8, "R5 clamp rxnum", d[12:8], 8);
        rd(8'hB8, d); check(d == {24'h0, slv_byte(7)}, "R5 last entry", d, slv_byte(7));

        // R11 command while busy
        begin
            logic [31:0] s;
            ncap = 0; nmiso = 0; cs_seen = '0; miso_i = slv_bit(0);
            wr(8'h10, 32'h0000_0202);
            repeat (5) @(negedge clk);
            wr(8'h10, 32'h0000_0808);
            rd(8'h10, d); check(d[4:0] == 2, "R11 cmd unchanged", d[4:0], 2);
            rd(8'h08, s);
            while (s[0]) begin @(negedge clk); rd(8'h08, s); end
            check(ncap == 16, "R11 transfer unchanged", ncap, 16);
        end

        // R8 disabled line
        set_cfg(1, 0, 0, 0, 0, 4'b1101, 1);
        run_cmd(1, 1, 0, 1, cyc);
        check(cs_seen == 4'b0000, "R8 disabled line", cs_seen, 0);

        // R13 disable
        set_cfg(0, 0, 0, 0, 0, 4'hF, 1);
        check({sclk_oe, mosi_oe, cs_oe} == 3'b0, "R13 oe off", {sclk_oe, mosi_oe, cs_oe}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule